// File: doc/BRIEF.md
# I2C Slave Transmitter with Clock Stretching

This block is the slave side of an I2C bus for read transfers. After a START it collects the first byte and compares its upper seven bits with a programmable own address. When the addresses match, it drives the programmed acknowledge level in the ninth clock slot. If the direction bit asks for a read, it moves into transmit mode by itself. A local host then feeds it bytes one at a time through a pulse-driven register interface. The block shifts each byte onto SDA, most significant bit first, and samples the master's acknowledge.

The handshake with the host rests on two flags. The empty flag rises whenever the one-byte holding buffer has been handed to the shifter. The done flag rises at the end of an acknowledge clock when no further byte is waiting. If the master acknowledges and the buffer is empty, the block holds SCL low until the host either supplies a byte or finishes the transfer. To finish, the host clears transmit mode, issues a dummy read of the receive register (this releases SCL), and then clears the empty flag. A STOP, a repeated START or a master NACK returns the block to listening. Both bus lines pass through a two-stage synchroniser and an agreement filter before any edge is decoded.

Top module: `i2c_slv_tx`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` and `scl_oe` are 0, and `tx_mode`, `tx_empty`, `tx_done` and `peer_nack` are 0.
- R2: Only the first byte after a START is compared. Its bits 7..1 are checked against `own_addr`, and the byte is kept in `rx_data`. On a mismatch the block leaves SDA released, and it ignores every further byte until the next START.
- R3: On a match, SDA is pulled low in the ninth clock slot when `ack_level` is 0 and left released when `ack_level` is 1. The level is applied from the eighth SCL falling edge, so it is valid at the ninth rising edge, and it is held to the ninth falling edge.
- R4: A matched address byte with bit 0 (direction) equal to 1 sets `tx_mode` and `tx_empty` to 1. With bit 0 equal to 0, `tx_mode` stays 0.
- R5: A `tx_wr` pulse stores `tx_data` and clears `tx_empty`. Moving the stored byte into the shifter sets `tx_empty` again. Bytes go out MSB first, and the block changes SDA only while SCL is low.
- R6: The master's acknowledge bit is sampled at the ninth SCL rising edge of each transmitted byte into `peer_nack` (1 = NACK, 0 = ACK).
- R7: At the end of an acknowledge clock, `tx_done` is set if `tx_empty` is 1. A `done_clr` pulse clears it.
- R8: After an acknowledge clock that ends in ACK, with `tx_mode` at 1 and no byte waiting, `scl_oe` stays 1 until a byte is written or the release sequence completes.
- R9: In the stretched state, an `rx_rd` pulse while `tx_mode` is 0 releases SCL and returns the block to listening. The sequence is `mode_clr`, then `rx_rd`, then `empty_clr`. An `empty_clr` pulse clears `tx_empty`.
- R10: A STOP on the bus, or a NACK from the master at the end of a byte, clears `tx_mode`, releases both lines and returns the block to listening.
- R11: While `en` is 0, the block drives neither line and does not respond to any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| scl_oe | output | 1 | 1 pulls SCL low (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| en | input | 1 | Block enable |
| own_addr | input | 7 | Slave address |
| ack_level | input | 1 | Level for the address acknowledge slot, 0 = ACK |
| tx_wr | input | 1 | Write pulse for the transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Read pulse on the receive register |
| rx_data | output | 8 | Last address byte received |
| mode_clr | input | 1 | Clears transmit mode |
| empty_clr | input | 1 | Clears the empty flag |
| done_clr | input | 1 | Clears the done flag |
| tx_mode | output | 1 | Transmit mode active |
| tx_empty | output | 1 | Holding buffer free for a new byte |
| tx_done | output | 1 | Last byte and its acknowledge clock finished |
| peer_nack | output | 1 | Master's last acknowledge bit |

## Verification
The hardest state to reach is the stretched acknowledge boundary. It needs a master that has acknowledged, a host that has run dry, and a master that is trying to raise SCL against the block. The bench gets there with a bus master model that waits on the wired-AND SCL level. The host thread deliberately delays its first write, and later stops writing after the third byte. The bench checks `scl_oe` and the bus while SCL is held, and then walks through the clear, dummy-read and empty-clear steps. A mid-transfer STOP is reached by preloading a second byte whose top bit is 1, so the block leaves SDA free for the master to form the STOP.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_HOLD
  } slv_st_e;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_line_filt.sv
module i2c_line_filt #(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned FILT_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [FILT_N-1:0] win_q, win_d;
  logic              lvl_q, lvl_d;
  logic              rise_q, fall_q;

  always_comb begin
    sync_d = {sync_q[SYNC_N-2:0], line_i};
    win_d  = {win_q[FILT_N-2:0], sync_q[SYNC_N-1]};
    if (&win_q)       lvl_d = 1'b1;
    else if (~|win_q) lvl_d = 1'b0;
    else              lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      lvl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      win_q  <= win_d;
      lvl_q  <= lvl_d;
      rise_q <= lvl_d & ~lvl_q;
      fall_q <= ~lvl_d & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_level,
  input  logic              scl_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              mode_clr,
  input  logic              empty_clr,
  input  logic              done_clr,
  output logic              sda_oe,
  output logic              scl_hold,
  output logic              tx_mode,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              peer_nack,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_TXLAST = CNT_W'(BYTE_W - 1);

  slv_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              sda_oe_q, sda_oe_d;
  logic              rw_q, rw_d;
  logic              mode_q, mode_d;
  logic              empty_q, empty_d;
  logic              done_q, done_d;
  logic              nack_q, nack_d;
  logic              load;
  logic              start_ev, stop_ev;

  assign start_ev = sda_fall & scl_f;
  assign stop_ev  = sda_rise & scl_f;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    buf_d    = buf_q;
    rx_d     = rx_q;
    sda_oe_d = sda_oe_q;
    rw_d     = rw_q;
    mode_d   = mode_q;
    empty_d  = empty_q;
    done_d   = done_q;
    nack_d   = nack_q;
    load     = 1'b0;

    if (tx_wr) begin
      buf_d   = tx_data;
      empty_d = 1'b0;
    end
    if (empty_clr) empty_d = 1'b0;
    if (done_clr)  done_d  = 1'b0;
    if (mode_clr)  mode_d  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
      end
      ST_ADDR: begin
        if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_f};
          cnt_d = cnt_q + 1'b1;
        end else if (scl_fall && cnt_q == CNT_FULL) begin
          rx_d  = sh_q;
          cnt_d = '0;
          if (sh_q[BYTE_W-1:1] == own_addr) begin
            st_d     = ST_AACK;
            sda_oe_d = ~ack_level;
            rw_d     = sh_q[0];
            if (sh_q[0]) begin
              mode_d  = 1'b1;
              empty_d = 1'b1;
              done_d  = 1'b0;
            end
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_AACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          if (!rw_q)                   st_d = ST_IDLE;
          else if (mode_q && !empty_q) load = 1'b1;
          else                         st_d = ST_HOLD;
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          if (cnt_q == CNT_TXLAST) begin
            st_d     = ST_TACK;
            sda_oe_d = 1'b0;
            cnt_d    = '0;
          end else begin
            cnt_d    = cnt_q + 1'b1;
            sh_d     = {sh_q[BYTE_W-2:0], 1'b0};
            sda_oe_d = ~sh_q[BYTE_W-2];
          end
        end
      end
      ST_TACK: begin
        if (scl_rise) nack_d = sda_f;
        if (scl_fall) begin
          if (empty_q) done_d = 1'b1;
          if (nack_q) begin
            mode_d = 1'b0;
            st_d   = ST_IDLE;
          end else if (mode_q && !empty_q) begin
            load = 1'b1;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (mode_q && !empty_q)    load = 1'b1;
        else if (!mode_q && rx_rd) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (load) begin
      sh_d     = buf_q;
      empty_d  = 1'b1;
      sda_oe_d = ~buf_q[BYTE_W-1];
      cnt_d    = '0;
      st_d     = ST_TX;
    end

    if (start_ev) begin
      st_d     = ST_ADDR;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
      mode_d   = 1'b0;
    end else if (stop_ev) begin
      st_d     = ST_IDLE;
      sda_oe_d = 1'b0;
      mode_d   = 1'b0;
    end

    if (!en) begin
      st_d     = ST_IDLE;
      sda_oe_d = 1'b0;
      mode_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      buf_q    <= '0;
      rx_q     <= '0;
      sda_oe_q <= 1'b0;
      rw_q     <= 1'b0;
      mode_q   <= 1'b0;
      empty_q  <= 1'b0;
      done_q   <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      buf_q    <= buf_d;
      rx_q     <= rx_d;
      sda_oe_q <= sda_oe_d;
      rw_q     <= rw_d;
      mode_q   <= mode_d;
      empty_q  <= empty_d;
      done_q   <= done_d;
      nack_q   <= nack_d;
    end
  end

  assign sda_oe    = sda_oe_q;
  assign scl_hold  = (st_q == ST_HOLD);
  assign tx_mode   = mode_q;
  assign tx_empty  = empty_q;
  assign tx_done   = done_q;
  assign peer_nack = nack_q;
  assign rx_data   = rx_q;

  // R4: entering transmit mode always comes with a free buffer
  p_mode_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> empty_q);

  // R5: own SDA drive moves only while the filtered SCL is low
  p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_q != $past(sda_oe_q)) && $past(en) && !$past(start_ev) && !$past(stop_ev))
      |-> !$past(scl_f));

  // R6: master acknowledge captured only at an acknowledge-clock rising edge
  p_nack_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_q != $past(nack_q)) |-> ($past(scl_rise) && ($past(st_q) == ST_TACK)));

  // R7: done rises only at a falling SCL edge with the buffer empty
  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(empty_q) && $past(scl_fall)));

  // R11: disabling stops all driving
  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe_q && (st_q == ST_IDLE)));
endmodule

// File: rtl/i2c_slv_tx.sv
module i2c_slv_tx
  import i2c_slv_pkg::*;
#(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned FILT_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_level,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              mode_clr,
  input  logic              empty_clr,
  input  logic              done_clr,
  output logic              tx_mode,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              peer_nack
);
  localparam int unsigned N_LINES = 2;

  logic               rst_s;
  logic [N_LINES-1:0] line_in, line_lvl, line_rise, line_fall;

  assign line_in = {sda_i, scl_i};

  i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_s)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filt #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_filt (
      .clk    (clk),
      .rst_n  (rst_s),
      .line_i (line_in[g]),
      .lvl_o  (line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  i2c_slv_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .en        (en),
    .own_addr  (own_addr),
    .ack_level (ack_level),
    .scl_f     (line_lvl[0]),
    .scl_rise  (line_rise[0]),
    .scl_fall  (line_fall[0]),
    .sda_f     (line_lvl[1]),
    .sda_rise  (line_rise[1]),
    .sda_fall  (line_fall[1]),
    .tx_wr     (tx_wr),
    .tx_data   (tx_data),
    .rx_rd     (rx_rd),
    .mode_clr  (mode_clr),
    .empty_clr (empty_clr),
    .done_clr  (done_clr),
    .sda_oe    (sda_oe),
    .scl_hold  (scl_oe),
    .tx_mode   (tx_mode),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .peer_nack (peer_nack),
    .rx_data   (rx_data)
  );

  // R8: a stretch with a byte waiting in transmit mode ends on the next cycle
  p_stretch_end_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (scl_oe && tx_mode && !tx_empty && en) |=> !scl_oe);
endmodule

// File: tb/sim_i2c_slv_tx.sv
module sim_i2c_slv_tx;
  localparam int Q = 25;
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, en, ack_level, tx_wr, rx_rd, mode_clr, empty_clr, done_clr;
  logic [6:0] own_addr;
  logic [7:0] tx_data, rx_data;
  logic       scl_oe, sda_oe, tx_mode, tx_empty, tx_done, peer_nack;
  logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_slv_tx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .en(en), .own_addr(own_addr),
    .ack_level(ack_level), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .mode_clr(mode_clr), .empty_clr(empty_clr),
    .done_clr(done_clr), .tx_mode(tx_mode), .tx_empty(tx_empty),
    .tx_done(tx_done), .peer_nack(peer_nack)
  );

  int         n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic       mon_v = 1'b0;
  logic [7:0] mon_b = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares each byte the master read with the queue
  always @(posedge clk) begin
    if (mon_v) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R5 unexpected byte actual=%0h expected=none", mon_b);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (e !== mon_b) begin
          n_err++;
          $display("FAIL R5 byte order actual=%0h expected=%0h", mon_b, e);
        end
      end
    end
  end

  // bus master model
  task automatic scl_pulse(output logic smp);
    m_scl_lo = 1'b0;
    do @(negedge clk); while (!scl_bus);
    tick(Q);
    smp = sda_bus;
    tick(Q);
    m_scl_lo = 1'b1;
    tick(Q);
  endtask

  task automatic m_start;
    m_sda_lo = 1'b0;
    tick(Q);
    m_scl_lo = 1'b0;
    do @(negedge clk); while (!scl_bus);
    tick(Q);
    m_sda_lo = 1'b1;
    tick(Q);
    m_scl_lo = 1'b1;
    tick(Q);
  endtask

  task automatic m_stop;
    m_sda_lo = 1'b1;
    tick(Q);
    m_scl_lo = 1'b0;
    do @(negedge clk); while (!scl_bus);
    tick(Q);
    m_sda_lo = 1'b0;
    tick(2 * Q);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda_lo = !b[i];
      tick(Q);
      scl_pulse(s);
    end
    m_sda_lo = 1'b0;
    tick(Q);
    scl_pulse(ack);
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    m_sda_lo = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_pulse(s);
      b = {b[6:0], s};
    end
    mon_b = b;
    mon_v = 1'b1;
    tick(1);
    mon_v = 1'b0;
    m_sda_lo = give_ack;
    tick(Q);
    scl_pulse(s);
    m_sda_lo = 1'b0;
  endtask

  // host driver
  task automatic h_write(input logic [7:0] b, input logic expect_read);
    tx_data = b;
    tx_wr   = 1'b1;
    if (expect_read) exp_q.push_back(b);
    tick(1);
    tx_wr = 1'b0;
  endtask

  task automatic h_pulse(input int which);
    case (which)
      0: mode_clr  = 1'b1;
      1: empty_clr = 1'b1;
      2: done_clr  = 1'b1;
      default: rx_rd = 1'b1;
    endcase
    tick(1);
    mode_clr = 1'b0; empty_clr = 1'b0; done_clr = 1'b0; rx_rd = 1'b0;
  endtask

  task automatic wait_empty;
    while (!tx_empty) tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    rst_n = 1'b0; en = 1'b0; own_addr = MY_ADDR; ack_level = 1'b0;
    tx_wr = 1'b0; tx_data = '0; rx_rd = 1'b0;
    mode_clr = 1'b0; empty_clr = 1'b0; done_clr = 1'b0;
    tick(5);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset flags", {tx_mode, tx_empty, tx_done, peer_nack}, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 after reset flags", {scl_oe, sda_oe, tx_mode, tx_empty, tx_done, peer_nack}, 0);
    en = 1'b1;
    tick(10);

    // R2: mismatch, then a matching byte without START is ignored
    m_start;
    m_wbyte(8'h2B, a);
    chk("R2 mismatch not acked", a, 1);
    m_wbyte({MY_ADDR, 1'b0}, a);
    chk("R2 ignored until START", a, 1);
    m_stop;

    // R3/R4: write direction with both acknowledge levels
    ack_level = 1'b1;
    m_start;
    m_wbyte({MY_ADDR, 1'b0}, a);
    chk("R3 ack_level 1 releases", a, 1);
    ack_level = 1'b0;
    m_start;
    m_wbyte({MY_ADDR, 1'b0}, a);
    chk("R3 ack_level 0 pulls low", a, 0);
    chk("R4 write direction keeps tx_mode 0", tx_mode, 0);
    chk("R2 rx_data holds address byte", rx_data, {MY_ADDR, 1'b0});
    m_stop;

    // R4..R9: read with stretching and the release sequence
    fork
      begin
        m_start;
        m_wbyte({MY_ADDR, 1'b1}, a);
        chk("R3 read address acked", a, 0);
        chk("R4 tx_mode set", tx_mode, 1);
        chk("R4 tx_empty set", tx_empty, 1);
        m_rbyte(1'b1, rb);
        m_rbyte(1'b1, rb);
        m_rbyte(1'b1, rb);
        chk("R6 master ack recorded", peer_nack, 0);
        m_stop;
      end
      begin
        wait_empty;
        tick(200);
        chk("R8 scl held before first byte", scl_oe, 1);
        chk("R8 bus scl low", scl_bus, 0);
        h_write(8'hA5, 1'b1);
        wait_empty;
        h_write(8'h3C, 1'b1);
        wait_empty;
        h_write(8'h81, 1'b1);
        while (!tx_done) tick(1);
        tick(20);
        chk("R8 scl held after last byte", scl_oe, 1);
        chk("R7 empty with done", tx_empty, 1);
        h_pulse(2);
        chk("R7 done cleared", tx_done, 0);
        h_pulse(0);
        tick(3);
        chk("R9 still held before dummy read", scl_oe, 1);
        h_pulse(3);
        tick(3);
        chk("R9 released after dummy read", scl_oe, 0);
        h_pulse(1);
        chk("R9 empty cleared", tx_empty, 0);
      end
    join
    tick(20);

    // R6/R10: master NACK on the last byte
    fork
      begin
        m_start;
        m_wbyte({MY_ADDR, 1'b1}, a);
        chk("R3 second read acked", a, 0);
        m_rbyte(1'b1, rb);
        m_rbyte(1'b0, rb);
        chk("R6 nack recorded", peer_nack, 1);
        chk("R10 nack clears tx_mode", tx_mode, 0);
        chk("R10 nack no stretch", scl_oe, 0);
        chk("R7 done after last byte", tx_done, 1);
        m_stop;
      end
      begin
        wait_empty;
        h_write(8'h5A, 1'b1);
        wait_empty;
        h_write(8'hC3, 1'b1);
      end
    join
    h_pulse(2);
    h_pulse(1);
    tick(20);

    // R10: STOP while the next byte is already loaded
    fork
      begin
        m_start;
        m_wbyte({MY_ADDR, 1'b1}, a);
        m_rbyte(1'b1, rb);
        m_stop;
        chk("R10 stop clears tx_mode", tx_mode, 0);
        chk("R10 stop releases sda", sda_oe, 0);
      end
      begin
        wait_empty;
        h_write(8'h96, 1'b1);
        wait_empty;
        h_write(8'hF0, 1'b0);
      end
    join
    h_pulse(2);
    h_pulse(1);
    tick(20);

    // R11: disabled block ignores its address
    en = 1'b0;
    tick(5);
    m_start;
    m_wbyte({MY_ADDR, 1'b1}, a);
    chk("R11 no ack when disabled", a, 1);
    chk("R11 no tx_mode when disabled", tx_mode, 0);
    chk("R11 no stretch when disabled", scl_oe, 0);
    m_stop;
    en = 1'b1;

    chk("R5 all written bytes read", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule